// File: doc/BRIEF.md
# Categorized Maskable Interrupt Vectoring Unit

This block gathers interrupt requests from five fixed categories: external signals, data exceptions, result exceptions, instruction exceptions and machine malfunctions. It picks one of them to service. A request sets a pending flag, and the flag stays set until the handler acknowledges it. The three program-specific categories (data, result and instruction exceptions) can each be suppressed by a per-program mask bit. A suppressed request stays pending. The external and malfunction categories can never be suppressed.

When interrupts are enabled, nothing is in service and at least one pending request is eligible, the unit issues a one-cycle fetch strobe. The strobe carries the address of the handler-table entry, which is the programmable table base plus the category number minus one. The unit never drives or alters the program counter: it only asks for the handler address, so software can still save the interrupted location. After a take, the unit blocks further vectoring until two things have happened: the handler acknowledges, and software re-enables interrupts.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset no category is pending, interrupts are disabled, the mask is zero, the table base is zero, and `fetch_o`, `fetch_addr_o` and `fetch_id_o` are all zero.
- R2: A high `req_i[k]` at a clock edge makes category k+1 pending. The flag stays set until an acknowledge of that same category, which clears it. A request arriving in the same cycle as the acknowledge leaves the flag set.
- R3: Mask bit 0, 1 or 2 (value 1 = suppressed) blocks category 2, 3 or 4 respectively. A blocked request stays pending and is taken once its bit is cleared.
- R4: Categories 1 and 5 are taken whatever the mask holds.
- R5: Among eligible categories, category 5 goes first, then 1, 2, 3 and 4 in that order.
- R6: `fetch_addr_o` equals the table base plus the category number minus one, modulo 2^AW. It uses the base and mask held in the cycle the decision is made, so a write in that same cycle takes effect only afterwards.
- R7: A take raises `fetch_o` for exactly one cycle. This is the cycle after the decision cycle, and the decision cycle is the first one in which a pending flag is visible. `fetch_id_o` holds the category number (1 to 5) from the strobe until the acknowledge, and is 0 otherwise.
- R8: A take clears the interrupt enable. No further strobe comes until the acknowledge has been given and `int_enable_i` has been pulsed, in either order. A request pending while interrupts are disabled is taken once enabled.
- R9: `ack_i` while nothing is in service has no effect on any pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Request lines, bit k = category k+1 |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | 3 | New mask, bit j suppresses category j+2 |
| base_we_i | input | 1 | Write strobe for the table base |
| base_wdata_i | input | AW | New table base |
| int_enable_i | input | 1 | Pulse to enable interrupts |
| ack_i | input | 1 | Handler acknowledge of the category in service |
| fetch_o | output | 1 | One-cycle handler fetch strobe |
| fetch_addr_o | output | AW | Table entry address during the strobe, else 0 |
| fetch_id_o | output | 3 | Category in service, 0 when idle |

## Verification
The directed cases cover the following situations, and each catches a specific kind of fault:

- All five categories pending at once. A design with the wrong priority order would vector category 1 ahead of the malfunction category.
- A fully masked set of program exceptions, followed by clearing a single mask bit. A design that drops masked requests would never vector after the unmask. A design that ignores the mask would vector at once.
- A table base near the top of the address range. A design that does not wrap would produce a wrong entry address.
- An acknowledge in the same cycle as a fresh request from the same category. A design that gives the clear priority would lose the second event.
- An acknowledge while idle. A design that acts on it would wrongly clear pending state.

Random stimulus then mixes all of these cases against a cycle-level model.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NUM_CAT = 5;
  localparam int MSK_W   = 3;
  localparam int ID_W    = 3;
  localparam int CAT_MALF = NUM_CAT;
  typedef logic [ID_W-1:0] cat_id_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_vec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CAT-1:0] req_i,
  input  logic [NUM_CAT-1:0] clr_i,
  input  logic [MSK_W-1:0]   mask_i,
  output logic [NUM_CAT-1:0] pend_o,
  output logic [NUM_CAT-1:0] elig_o
);
  logic [NUM_CAT-1:0] pend_q;
  logic [NUM_CAT-1:0] pend_d;
  logic [NUM_CAT-1:0] pend_en;

  for (genvar i = 0; i < NUM_CAT; i++) begin : g_cat
    assign pend_en[i] = req_i[i] | clr_i[i];
    assign pend_d[i]  = req_i[i] | (pend_q[i] & ~clr_i[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else if (pend_en[i]) pend_q[i] <= pend_d[i];
    end

    if (i >= 1 && i <= MSK_W) begin : g_maskable
      assign elig_o[i] = pend_q[i] & ~mask_i[i-1];
    end else begin : g_fixed
      assign elig_o[i] = pend_q[i];
    end

    // R2: a request is remembered
    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[i] |=> pend_q[i]);
    // R2: pending persists until cleared
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_vec_pkg::*;
(
  input  logic [NUM_CAT-1:0] elig_i,
  output logic               valid_o,
  output cat_id_t            id_o
);
  always_comb begin
    valid_o = |elig_i;
    id_o    = '0;
    if (elig_i[NUM_CAT-1]) begin
      id_o = cat_id_t'(CAT_MALF);
    end else begin
      for (int k = NUM_CAT - 2; k >= 0; k--) begin
        if (elig_i[k]) id_o = cat_id_t'(k + 1);
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we_i,
  input  logic [MSK_W-1:0]   mask_wdata_i,
  input  logic               base_we_i,
  input  logic [AW-1:0]      base_wdata_i,
  input  logic               int_enable_i,
  input  logic               ack_i,
  input  logic               sel_valid_i,
  input  cat_id_t            sel_id_i,
  input  logic [NUM_CAT-1:0] elig_i,
  output logic [MSK_W-1:0]   mask_o,
  output logic [NUM_CAT-1:0] clr_o,
  output logic               fetch_o,
  output logic [AW-1:0]      addr_o,
  output cat_id_t            id_o
);
  logic [MSK_W-1:0] mask_q;
  logic [AW-1:0]    base_q;
  logic             ien_q, ien_d;
  logic             busy_q, busy_d;
  cat_id_t          cur_q, cur_d;
  logic             fetch_q;
  logic [AW-1:0]    addr_q, addr_d;
  logic             take;
  logic             done;

  always_comb begin
    take   = ien_q & ~busy_q & sel_valid_i;
    done   = ack_i & busy_q;
    ien_d  = ien_q;
    busy_d = busy_q;
    cur_d  = cur_q;
    addr_d = '0;
    clr_o  = '0;
    if (done) begin
      clr_o[cur_q - cat_id_t'(1)] = 1'b1;
      busy_d = 1'b0;
      cur_d  = '0;
    end
    if (int_enable_i) ien_d = 1'b1;
    if (take) begin
      ien_d  = 1'b0;
      busy_d = 1'b1;
      cur_d  = sel_id_i;
      addr_d = base_q + AW'(sel_id_i) - AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      base_q  <= '0;
      ien_q   <= 1'b0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      fetch_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (base_we_i) base_q <= base_wdata_i;
      ien_q   <= ien_d;
      busy_q  <= busy_d;
      cur_q   <= cur_d;
      fetch_q <= take;
      addr_q  <= addr_d;
    end
  end

  assign mask_o  = mask_q;
  assign fetch_o = fetch_q;
  assign addr_o  = addr_q;
  assign id_o    = cur_q;

  // R7: strobe lasts one cycle
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |=> !fetch_q);
  // R8: nothing vectors while a category is in service
  a_r8_blocked_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !fetch_q);
  // R8: enable dropped by the take
  a_r8_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |-> !ien_q);
  // R6: entry address from base at decision time
  a_r6_entry_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |-> (addr_q == $past(base_q) + AW'(cur_q) - AW'(1)));
  // R5: malfunction first
  a_r5_malf_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q && $past(elig_i[NUM_CAT-1])) |-> (cur_q == cat_id_t'(CAT_MALF)));
  // R4: external category beats all maskable ones
  a_r4_ext_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q && $past(elig_i[0]) && !$past(elig_i[NUM_CAT-1])) |-> (cur_q == cat_id_t'(1)));

  for (genvar k = 0; k < MSK_W; k++) begin : g_mask_chk
    // R3: a suppressed category is never vectored
    a_r3_masked_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_q && cur_q == cat_id_t'(k + 2)) |-> !$past(mask_q[k]));
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vec_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CAT-1:0] req_i,
  input  logic               mask_we_i,
  input  logic [MSK_W-1:0]   mask_wdata_i,
  input  logic               base_we_i,
  input  logic [AW-1:0]      base_wdata_i,
  input  logic               int_enable_i,
  input  logic               ack_i,
  output logic               fetch_o,
  output logic [AW-1:0]      fetch_addr_o,
  output logic [ID_W-1:0]    fetch_id_o
);
  logic [NUM_CAT-1:0] pend;
  logic [NUM_CAT-1:0] elig;
  logic [NUM_CAT-1:0] clr;
  logic [MSK_W-1:0]   mask;
  logic               sel_valid;
  cat_id_t            sel_id;

  irq_pend_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .clr_i  (clr),
    .mask_i (mask),
    .pend_o (pend),
    .elig_o (elig)
  );

  irq_prio_pick u_pick (
    .elig_i  (elig),
    .valid_o (sel_valid),
    .id_o    (sel_id)
  );

  irq_vec_ctrl #(.AW(AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .base_we_i    (base_we_i),
    .base_wdata_i (base_wdata_i),
    .int_enable_i (int_enable_i),
    .ack_i        (ack_i),
    .sel_valid_i  (sel_valid),
    .sel_id_i     (sel_id),
    .elig_i       (elig),
    .mask_o       (mask),
    .clr_o        (clr),
    .fetch_o      (fetch_o),
    .addr_o       (fetch_addr_o),
    .id_o         (fetch_id_o)
  );

  // R7: the vectored category was pending when the strobe rises
  a_r7_id_pending: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> pend[fetch_id_o - 3'd1]);
  // R9: idle acknowledge leaves pending flags alone
  a_r9_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && fetch_id_o == 3'd0) |-> (clr == '0));
endmodule

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    req_i = '0;
  logic          mask_we_i = 1'b0;
  logic [2:0]    mask_wdata_i = '0;
  logic          base_we_i = 1'b0;
  logic [AW-1:0] base_wdata_i = '0;
  logic          int_enable_i = 1'b0;
  logic          ack_i = 1'b0;
  logic          fetch_o;
  logic [AW-1:0] fetch_addr_o;
  logic [2:0]    fetch_id_o;

  always #2.5 clk = ~clk;

  irq_vector_unit #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .base_we_i(base_we_i), .base_wdata_i(base_wdata_i),
    .int_enable_i(int_enable_i), .ack_i(ack_i),
    .fetch_o(fetch_o), .fetch_addr_o(fetch_addr_o), .fetch_id_o(fetch_id_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // reference state
  logic [4:0]    m_pend = '0;
  logic [2:0]    m_mask = '0;
  logic [AW-1:0] m_base = '0;
  logic          m_ien = 1'b0, m_busy = 1'b0, m_fetch = 1'b0;
  logic [2:0]    m_cur = '0;
  logic [AW-1:0] m_addr = '0;

  function automatic logic [4:0] eligible(logic [4:0] p, logic [2:0] m);
    return p & {1'b1, ~m, 1'b1};
  endfunction

  function automatic logic [2:0] pick(logic [4:0] e);
    if (e[4]) return 3'd5;
    for (int k = 0; k < 4; k++) if (e[k]) return 3'(k + 1);
    return 3'd0;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (fetch_o !== m_fetch || fetch_addr_o !== m_addr || fetch_id_o !== m_cur) begin
      n_err++;
      $display("FAIL %s: got fetch=%0b addr=%h id=%0d, expected fetch=%0b addr=%h id=%0d",
               tag, fetch_o, fetch_addr_o, fetch_id_o, m_fetch, m_addr, m_cur);
    end
  endtask

  task automatic cyc(input logic [4:0] rq, input logic mwe, input logic [2:0] mw,
                     input logic bwe, input logic [AW-1:0] bw,
                     input logic en, input logic ak, input string tag);
    logic [4:0] e;
    logic take, done;
    logic [4:0] np;
    logic nien, nbusy;
    logic [2:0] ncur;
    logic [AW-1:0] naddr;
    req_i = rq; mask_we_i = mwe; mask_wdata_i = mw; base_we_i = bwe;
    base_wdata_i = bw; int_enable_i = en; ack_i = ak;
    e = eligible(m_pend, m_mask);
    take = m_ien && !m_busy && (e != 0);
    done = ak && m_busy;
    np = m_pend;
    if (done) np[m_cur - 3'd1] = 1'b0;
    np = np | rq;
    nien = take ? 1'b0 : (en ? 1'b1 : m_ien);
    nbusy = m_busy; ncur = m_cur; naddr = '0;
    if (done) begin nbusy = 1'b0; ncur = 3'd0; end
    if (take) begin
      nbusy = 1'b1; ncur = pick(e);
      naddr = m_base + AW'(pick(e)) - AW'(1);
    end
    @(posedge clk);
    m_pend = np; m_ien = nien; m_busy = nbusy; m_cur = ncur;
    m_fetch = take; m_addr = naddr;
    if (mwe) m_mask = mw;
    if (bwe) m_base = bw;
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(5'b0, 0, 3'b0, 0, '0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");

    // R8: disabled unit holds request until enabled
    cyc(5'b00001, 0, 0, 0, '0, 0, 0, "R2 latch");
    idle(3, "R8 disabled no fetch");
    cyc(5'b0, 0, 0, 0, '0, 1, 0, "R8 enable");
    idle(2, "R7 strobe cat1");
    cyc(5'b0, 0, 0, 0, '0, 0, 1, "R8 ack");
    cyc(5'b0, 0, 0, 0, '0, 1, 0, "R8 re-enable no pending");
    idle(2, "R2 cleared by ack");

    // R3: masked categories wait
    cyc(5'b01110, 1, 3'b111, 1, 16'h0100, 0, 0, "R3 set mask");
    idle(3, "R3 masked no fetch");
    cyc(5'b0, 0, 0, 0, '0, 0, 1, "R9 idle ack");
    cyc(5'b0, 1, 3'b101, 0, '0, 0, 0, "R3 unmask cat3");
    idle(2, "R6 cat3 address");
    cyc(5'b0, 0, 0, 0, '0, 0, 1, "R3 ack cat3");
    cyc(5'b0, 1, 3'b000, 0, '0, 1, 0, "R3 unmask all");
    idle(2, "R5 cat2 before cat4");
    cyc(5'b0, 0, 0, 0, '0, 1, 1, "R8 ack+enable same cycle");
    idle(2, "R5 cat4 next");
    cyc(5'b0, 0, 0, 0, '0, 0, 1, "R3 ack cat4");

    // R4, R5: all pending, full mask
    cyc(5'b11111, 1, 3'b111, 0, '0, 1, 0, "R4 all pending");
    idle(2, "R5 cat5 first");
    cyc(5'b0, 0, 0, 0, '0, 1, 1, "R5 ack cat5");
    idle(2, "R4 cat1 despite mask");
    cyc(5'b0, 0, 0, 0, '0, 0, 1, "R4 ack cat1");
    cyc(5'b0, 1, 3'b000, 0, '0, 1, 0, "R5 unmask");
    for (int i = 0; i < 3; i++) begin
      idle(2, "R5 order 2..4");
      cyc(5'b0, 0, 0, 0, '0, 1, 1, "R5 ack");
    end
    idle(2, "R5 drained");

    // R6: wrap, base write in decision cycle
    cyc(5'b10000, 0, 0, 1, 16'hFFFF, 1, 0, "R6 base wrap");
    cyc(5'b0, 0, 0, 1, 16'h2000, 0, 0, "R6 late base write");
    idle(1, "R6 wrap address");
    // R2: ack with same-category request keeps it pending
    cyc(5'b10000, 0, 0, 0, '0, 1, 1, "R2 ack+req");
    idle(2, "R2 retaken cat5");
    cyc(5'b0, 0, 0, 0, '0, 0, 1, "R2 final ack");
    idle(2, "R2 quiet");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] rq;
      rq = (($urandom % 4) == 0) ? 5'($urandom) : 5'b0;
      cyc(rq, ($urandom % 8) == 0, 3'($urandom), ($urandom % 16) == 0, AW'($urandom),
          ($urandom % 3) == 0, ($urandom % 3) == 0, "R7 random");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule